// File: doc/BRIEF.md
# Base-and-bounds address translator

This block sits between a processor's load/store port and the memory side. Every user-mode reference carries a virtual address that starts at zero. The block adds a base register to that address to form the physical address. First it compares the virtual address with a bounds register. A reference that lies outside the allowed window never reaches memory. Instead the block raises a one-cycle protection fault and reports the offending virtual address.

Supervisor software loads the base and bounds registers through two write ports, for example on a context switch. A write is honoured only while the mode input selects supervisor. In user mode the write is dropped and a separate privilege-violation fault is raised. In supervisor mode the block passes memory references straight through, with no base added and no bounds check.

The translation is registered. A physical address appears one cycle after the request is accepted. The request side accepts a new reference every cycle, as long as the memory side is not stalling.

Top module: `bb_xlate`

## Requirements
- R1: After reset, base and bounds are zero, and mem_valid, bnd_fault and priv_fault are low. Because the bounds value is zero, any user-mode request then raises bnd_fault.
- R2: A user-mode request (sup_mode=0) is accepted when req_valid and req_ready are both high. If its virtual address is below the bounds value, then in the next cycle mem_valid=1, mem_pa equals base plus the virtual address, and mem_wr equals the request's req_wr.
- R3: If a user-mode request has a virtual address greater than or equal to the bounds value, then in the next cycle mem_valid=0, bnd_fault=1 for exactly that cycle, and fault_va equals the virtual address. When no bounds fault is flagged, fault_va reads zero.
- R4: If base plus the virtual address carries out of the PA_W-bit physical width, the user-mode request is treated as a bounds fault, with the same outputs as R3.
- R5: A supervisor-mode request (sup_mode=1) gives mem_pa equal to the zero-extended virtual address, with no bounds check and no fault, whatever the register contents.
- R6: A base or bounds write made with sup_mode=1 applies to every request accepted in a later cycle. A request accepted in the same cycle as the write still uses the old value.
- R7: A base or bounds write attempted with sup_mode=0 leaves the register unchanged. It raises priv_fault for one cycle in the next cycle. A supervisor write never raises priv_fault.
- R8: While mem_valid=1 and mem_ready=0, req_ready is low, and mem_valid, mem_pa and mem_wr hold their values.
- R9: While mem_ready=1, req_ready stays high and back-to-back requests are accepted one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_mode | input | 1 | 1 = supervisor, 0 = user |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | PA_W | Base register write value |
| bound_we | input | 1 | Bounds register write strobe |
| bound_wdata | input | VA_W | Bounds register write value |
| req_valid | input | 1 | Memory reference request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_va | input | VA_W | Virtual address of the request |
| req_wr | input | 1 | 1 = store, 0 = load |
| mem_valid | output | 1 | Translated reference toward memory |
| mem_ready | input | 1 | Memory side takes the reference |
| mem_pa | output | PA_W | Physical address |
| mem_wr | output | 1 | Store flag toward memory |
| bnd_fault | output | 1 | One-cycle bounds/overflow protection fault |
| priv_fault | output | 1 | One-cycle user-mode register write fault |
| fault_va | output | VA_W | Virtual address of the faulting request |

## Verification
The hardest case to reach from the ports is the carry out of the physical width. It needs a base near the top of the physical space together with an address that is still below the bounds. The bench uses a small configuration with a 5-bit virtual and 6-bit physical address. It sweeps every base value against every bounds value and every virtual address, so every carry boundary is crossed. The expected address and fault are worked out arithmetically for each request. Directed sequences cover the remaining cases: a stalled memory side while a new request waits, ignored user-mode writes followed by translations that show the old register values, and supervisor bypass with a nonzero base.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic {
    PRIV_USER = 1'b0,
    PRIV_SUP  = 1'b1
  } priv_e;

  function automatic logic is_sup(input logic mode);
    return priv_e'(mode) == PRIV_SUP;
  endfunction

endpackage

// File: rtl/bb_regs.sv
module bb_regs
  import bb_pkg::*;
#(
  parameter int VA_W = 16,
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sup_mode,
  input  logic            base_we,
  input  logic [PA_W-1:0] base_wdata,
  input  logic            bound_we,
  input  logic [VA_W-1:0] bound_wdata,
  output logic [PA_W-1:0] base_q,
  output logic [VA_W-1:0] bound_q,
  output logic            priv_viol
);

  logic granted;

  assign granted   = is_sup(sup_mode);
  assign priv_viol = !granted && (base_we || bound_we);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      bound_q <= '0;
    end else if (granted) begin
      if (base_we)  base_q  <= base_wdata;
      if (bound_we) bound_q <= bound_wdata;
    end
  end

endmodule

// File: rtl/bb_calc.sv
module bb_calc
  import bb_pkg::*;
#(
  parameter int VA_W = 16,
  parameter int PA_W = 16
) (
  input  logic            sup_mode,
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-1:0] base,
  input  logic [VA_W-1:0] bound,
  output logic [PA_W-1:0] pa,
  output logic            viol
);

  localparam int SUM_W = PA_W + 1;

  logic [PA_W-1:0]  va_ext;
  logic [SUM_W-1:0] sum;
  logic             over_bound;
  logic             carry;

  assign va_ext     = PA_W'(va);
  assign sum        = {1'b0, base} + {1'b0, va_ext};
  assign over_bound = (va >= bound);
  assign carry      = sum[SUM_W-1];

  always_comb begin
    if (is_sup(sup_mode)) begin
      pa   = va_ext;
      viol = 1'b0;
    end else begin
      pa   = sum[PA_W-1:0];
      viol = over_bound || carry;
    end
  end

endmodule

// File: rtl/bb_stage.sv
module bb_stage #(
  parameter int VA_W = 16,
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [PA_W-1:0] cand_pa,
  input  logic            cand_wr,
  input  logic            cand_viol,
  input  logic [VA_W-1:0] cand_va,
  input  logic            priv_viol,
  input  logic            mem_ready,
  output logic            stage_free,
  output logic            mem_valid,
  output logic [PA_W-1:0] mem_pa,
  output logic            mem_wr,
  output logic            bnd_fault,
  output logic            priv_fault,
  output logic [VA_W-1:0] fault_va
);

  logic take_ok;
  logic take_bad;

  assign stage_free = !mem_valid || mem_ready;
  assign take_ok    = accept && !cand_viol;
  assign take_bad   = accept && cand_viol;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid  <= 1'b0;
      mem_pa     <= '0;
      mem_wr     <= 1'b0;
      bnd_fault  <= 1'b0;
      priv_fault <= 1'b0;
      fault_va   <= '0;
    end else begin
      bnd_fault  <= take_bad;
      fault_va   <= take_bad ? cand_va : '0;
      priv_fault <= priv_viol;
      if (stage_free) begin
        mem_valid <= take_ok;
        if (take_ok) begin
          mem_pa <= cand_pa;
          mem_wr <= cand_wr;
        end
      end
    end
  end

endmodule

// File: rtl/bb_xlate.sv
module bb_xlate #(
  parameter int VA_W = 16,
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sup_mode,
  input  logic            base_we,
  input  logic [PA_W-1:0] base_wdata,
  input  logic            bound_we,
  input  logic [VA_W-1:0] bound_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic            req_wr,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [PA_W-1:0] mem_pa,
  output logic            mem_wr,
  output logic            bnd_fault,
  output logic            priv_fault,
  output logic [VA_W-1:0] fault_va
);

  logic [PA_W-1:0] base_q;
  logic [VA_W-1:0] bound_q;
  logic            priv_viol;
  logic [PA_W-1:0] cand_pa;
  logic            cand_viol;
  logic            stage_free;
  logic            accept;

  assign req_ready = stage_free;
  assign accept    = req_valid && stage_free;

  bb_regs #(.VA_W(VA_W), .PA_W(PA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .sup_mode   (sup_mode),
    .base_we    (base_we),
    .base_wdata (base_wdata),
    .bound_we   (bound_we),
    .bound_wdata(bound_wdata),
    .base_q     (base_q),
    .bound_q    (bound_q),
    .priv_viol  (priv_viol)
  );

  bb_calc #(.VA_W(VA_W), .PA_W(PA_W)) u_calc (
    .sup_mode(sup_mode),
    .va      (req_va),
    .base    (base_q),
    .bound   (bound_q),
    .pa      (cand_pa),
    .viol    (cand_viol)
  );

  bb_stage #(.VA_W(VA_W), .PA_W(PA_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .cand_pa   (cand_pa),
    .cand_wr   (req_wr),
    .cand_viol (cand_viol),
    .cand_va   (req_va),
    .priv_viol (priv_viol),
    .mem_ready (mem_ready),
    .stage_free(stage_free),
    .mem_valid (mem_valid),
    .mem_pa    (mem_pa),
    .mem_wr    (mem_wr),
    .bnd_fault (bnd_fault),
    .priv_fault(priv_fault),
    .fault_va  (fault_va)
  );

endmodule

// File: rtl/bb_xlate_chk.sv
module bb_xlate_chk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            sup_mode,
  input logic            base_we,
  input logic            bound_we,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [PA_W-1:0] mem_pa,
  input logic            bnd_fault,
  input logic            priv_fault
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_valid && !bnd_fault && !priv_fault));

  // R3
  fault_blocks_mem_chk: assert property (@(posedge clk) disable iff (rst)
    bnd_fault |-> (!mem_valid && $past(req_valid && req_ready && !sup_mode)));

  // R5
  sup_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && sup_mode) |=> (mem_valid && !bnd_fault));

  // R7
  priv_cause_chk: assert property (@(posedge clk) disable iff (rst)
    priv_fault |-> $past(!sup_mode && (base_we || bound_we)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_pa)));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (mem_valid && !mem_ready));

endmodule

bind bb_xlate bb_xlate_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/tb_bb_xlate.sv
module tb_bb_xlate;

  localparam int VA_W = 5;
  localparam int PA_W = 6;
  localparam int NVA  = 1 << VA_W;
  localparam int NPA  = 1 << PA_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sup_mode = 1'b0;
  logic            base_we = 1'b0;
  logic [PA_W-1:0] base_wdata = '0;
  logic            bound_we = 1'b0;
  logic [VA_W-1:0] bound_wdata = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [VA_W-1:0] req_va = '0;
  logic            req_wr = 1'b0;
  logic            mem_valid;
  logic            mem_ready = 1'b1;
  logic [PA_W-1:0] mem_pa;
  logic            mem_wr;
  logic            bnd_fault;
  logic            priv_fault;
  logic [VA_W-1:0] fault_va;

  int nchk = 0;
  int nerr = 0;
  int m_base = 0;
  int m_bound = 0;

  always #5 clk = ~clk;

  bb_xlate #(.VA_W(VA_W), .PA_W(PA_W)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic sup, input logic is_base, input int val, input string tag);
    sup_mode = sup;
    base_we = is_base;
    bound_we = !is_base;
    base_wdata = PA_W'(val);
    bound_wdata = VA_W'(val);
    step();
    base_we = 1'b0;
    bound_we = 1'b0;
    chk({tag, " priv_fault"}, 32'(priv_fault), sup ? 0 : 1);
    if (sup) begin
      if (is_base) m_base = val;
      else m_bound = val;
    end
  endtask

  // user-mode request checked against the model
  task automatic ureq(input int va, input logic wr, input string tag);
    int sum;
    logic flt;
    sum = m_base + va;
    flt = (va >= m_bound) || (sum >= NPA);
    sup_mode = 1'b0;
    req_valid = 1'b1;
    req_va = VA_W'(va);
    req_wr = wr;
    step();
    req_valid = 1'b0;
    chk({tag, " mem_valid"}, 32'(mem_valid), flt ? 0 : 1);
    chk({tag, " bnd_fault"}, 32'(bnd_fault), flt ? 1 : 0);
    chk({tag, " fault_va"}, 32'(fault_va), flt ? va : 0);
    if (!flt) begin
      chk({tag, " mem_pa"}, 32'(mem_pa), sum);
      chk({tag, " mem_wr"}, 32'(mem_wr), 32'(wr));
    end
  endtask

  initial begin
    #1500000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mem_valid", 32'(mem_valid), 0);
    chk("R1 bnd_fault", 32'(bnd_fault), 0);
    chk("R1 priv_fault", 32'(priv_fault), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    ureq(0, 1'b0, "R1 zero bounds");
    ureq(17, 1'b1, "R1 zero bounds");

    // R2 R3 R4 R6 exhaustive sweep
    for (int b = 0; b < NPA; b++) begin
      for (int bd = 0; bd < NVA; bd++) begin
        wr_reg(1'b1, 1'b1, b, "R6 base");
        wr_reg(1'b1, 1'b0, bd, "R6 bound");
        for (int v = 0; v < NVA; v++) ureq(v, v[0], "R2/R3/R4 sweep");
      end
    end

    // R4 directed carry edge
    wr_reg(1'b1, 1'b1, 60, "R4 base");
    wr_reg(1'b1, 1'b0, 31, "R4 bound");
    ureq(3, 1'b0, "R4 no carry");
    ureq(4, 1'b0, "R4 carry");
    ureq(30, 1'b1, "R4 carry");

    // R5 supervisor bypass
    wr_reg(1'b1, 1'b1, 40, "R5 base");
    wr_reg(1'b1, 1'b0, 0, "R5 bound");
    for (int v = 0; v < NVA; v++) begin
      sup_mode = 1'b1;
      req_valid = 1'b1;
      req_va = VA_W'(v);
      req_wr = v[1];
      step();
      req_valid = 1'b0;
      chk("R5 mem_valid", 32'(mem_valid), 1);
      chk("R5 mem_pa", 32'(mem_pa), v);
      chk("R5 bnd_fault", 32'(bnd_fault), 0);
    end

    // R7 user writes ignored
    wr_reg(1'b1, 1'b1, 5, "R7 setup");
    wr_reg(1'b1, 1'b0, 10, "R7 setup");
    wr_reg(1'b0, 1'b1, 20, "R7 user base");
    ureq(3, 1'b0, "R7 base kept");
    wr_reg(1'b0, 1'b0, 2, "R7 user bound");
    ureq(9, 1'b1, "R7 bound kept");
    ureq(10, 1'b0, "R7 bound kept");
    sup_mode = 1'b0;
    base_we = 1'b1;
    bound_we = 1'b1;
    base_wdata = 6'd33;
    bound_wdata = 5'd1;
    step();
    base_we = 1'b0;
    bound_we = 1'b0;
    chk("R7 both we priv_fault", 32'(priv_fault), 1);
    step();
    chk("R7 pulse ends", 32'(priv_fault), 0);
    ureq(4, 1'b0, "R7 both kept");

    // R6 same-cycle write uses old base
    sup_mode = 1'b1;
    base_we = 1'b1;
    base_wdata = 6'd20;
    req_valid = 1'b1;
    req_va = 5'd7;
    step();
    base_we = 1'b0;
    req_valid = 1'b0;
    chk("R6 same cycle bypass pa", 32'(mem_pa), 7);
    m_base = 20;
    ureq(7, 1'b0, "R6 new base");

    // R8 backpressure
    wr_reg(1'b1, 1'b1, 10, "R8 base");
    wr_reg(1'b1, 1'b0, 31, "R8 bound");
    mem_ready = 1'b0;
    sup_mode = 1'b0;
    req_valid = 1'b1;
    req_va = 5'd2;
    req_wr = 1'b1;
    step();
    req_va = 5'd5;
    req_wr = 1'b0;
    chk("R8 first valid", 32'(mem_valid), 1);
    chk("R8 first pa", 32'(mem_pa), 12);
    chk("R8 ready low", 32'(req_ready), 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R8 hold valid", 32'(mem_valid), 1);
      chk("R8 hold pa", 32'(mem_pa), 12);
      chk("R8 hold wr", 32'(mem_wr), 1);
      chk("R8 hold ready", 32'(req_ready), 0);
    end
    mem_ready = 1'b1;
    step();
    req_valid = 1'b0;
    chk("R8 next valid", 32'(mem_valid), 1);
    chk("R8 next pa", 32'(mem_pa), 15);
    chk("R8 next wr", 32'(mem_wr), 0);
    step();
    chk("R8 drained", 32'(mem_valid), 0);

    // R9 back-to-back throughput
    for (int i = 0; i < 8; i++) begin
      chk("R9 ready", 32'(req_ready), 1);
      ureq(i * 3, i[0], "R9 burst");
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule